// File: doc/BRIEF.md
# Processor status control-field unit

This unit keeps the low byte of a processor status word: the IRQ-disable bit, the FIQ-disable bit, the instruction-state bit and the five-bit operating mode. A second register holds a saved copy of that byte. Software writes reach either copy through a per-bit mask. An exception-entry event moves the live byte into the saved copy and switches to a new mode, all on one clock edge.

The unit also gates the raw IRQ and FIQ requests before they reach the core. IRQ is blocked by the live IRQ-disable bit. FIQ is blocked by the live FIQ-disable bit, except in the non-secure state when the forward-write permit from the secure configuration is clear. In that case FIQ cannot be masked, and software writes cannot change the live FIQ-disable bit. The saved copy's FIQ-disable bit stays writable in that case.

Byte layout, used by both copies: bit 7 is the IRQ disable, bit 6 the FIQ disable, bit 5 the instruction state and bits 4:0 the mode. Mode codes: 10000 user, 10001 FIQ, 10010 IRQ, 10011 supervisor, 10110 monitor, 10111 abort, 11011 undefined, 11111 system. No other code is legal.

Top module: `psr_ctrl_unit`

## Requirements
- R1: After reset the live byte is 0xD3 (supervisor, both interrupts disabled, state bit 0), and the saved byte is also 0xD3.
- R2: irq_o equals irq_req_i AND NOT live bit 7, combinationally in the same cycle.
- R3: fiq_o equals fiq_req_i when secure_i=0 and fw_i=0. Otherwise fiq_o equals fiq_req_i AND NOT live bit 6. The output is combinational.
- R4: While the live mode is user (10000), software writes change neither the live byte nor the saved byte.
- R5: In a privileged mode, a live write (wr_en_i=1, wr_saved_i=0) takes the masked bits 7 and 6 and the masked mode bits from wr_data_i on the next clock edge. A software write never changes live bit 5.
- R6: A live write to bit 6 is dropped when secure_i=0 and fw_i=0. A saved-copy write to bit 6 takes effect in every security state.
- R7: If the masked merge of a live write gives an illegal mode code, the mode keeps its old value. The other masked bits of that write still update.
- R8: When exc_en_i=1 with a legal exc_mode_i, one edge does all of the following: the saved byte receives the old live byte, the mode becomes exc_mode_i, and bit 7 becomes 1. Bit 6 becomes 1 only for the FIQ target (10001) and otherwise holds. Bit 5 holds. A software write in the same cycle is discarded.
- R9: An exception event with an illegal target code changes neither the live byte nor the saved byte.
- R10: In a privileged mode, a saved-copy write (wr_en_i=1, wr_saved_i=1) replaces the masked bits of the saved byte, including bit 5 and the mode bits, with no legality check. The live byte does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write request |
| wr_saved_i | input | 1 | Write target: 0 live byte, 1 saved byte |
| wr_mask_i | input | 8 | Per-bit write enable |
| wr_data_i | input | 8 | Write data |
| secure_i | input | 1 | Core is in the secure state |
| fw_i | input | 1 | Forward-write permit for the FIQ-disable bit |
| exc_en_i | input | 1 | Exception entry event |
| exc_mode_i | input | 5 | Target mode of the exception |
| irq_req_i | input | 1 | Raw IRQ request |
| fiq_req_i | input | 1 | Raw FIQ request |
| ctrl_o | output | 8 | Live control byte |
| saved_o | output | 8 | Saved control byte |
| mode_o | output | 5 | Current mode |
| t_o | output | 1 | Instruction-state bit |
| irq_o | output | 1 | Gated IRQ to the core |
| fiq_o | output | 1 | Gated FIQ to the core |

## Verification
Register results lag by one edge: a write or exception driven in one cycle shows on ctrl_o and saved_o after the next rising edge. The driver pushes the expected pair of bytes once that edge has passed, and the monitor compares them on the following falling edge. The gated interrupt outputs have no delay. They are checked a short settle time after their inputs change, within the same low clock phase, with no edge between stimulus and sample.

// File: rtl/psr_ctrl_pkg.sv
package psr_ctrl_pkg;
  localparam int CTRL_W = 8;
  localparam int MODE_W = 5;
  localparam int BIT_I  = 7;
  localparam int BIT_F  = 6;
  localparam int BIT_T  = 5;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [CTRL_W-1:0] ctrl_t;

  localparam mode_t MODE_USR = 5'b10000;
  localparam mode_t MODE_FIQ = 5'b10001;
  localparam mode_t MODE_IRQ = 5'b10010;
  localparam mode_t MODE_SVC = 5'b10011;
  localparam mode_t MODE_MON = 5'b10110;
  localparam mode_t MODE_ABT = 5'b10111;
  localparam mode_t MODE_UND = 5'b11011;
  localparam mode_t MODE_SYS = 5'b11111;

  localparam ctrl_t CTRL_RST = {1'b1, 1'b1, 1'b0, MODE_SVC};
endpackage

// File: rtl/psr_mode_check.sv
module psr_mode_check
  import psr_ctrl_pkg::*;
(
  input  mode_t mode_i,
  output logic  legal_o
);
  always_comb begin
    unique case (mode_i)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_MON, MODE_ABT, MODE_UND, MODE_SYS: legal_o = 1'b1;
      default:                                legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/psr_live_reg.sv
module psr_live_reg
  import psr_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  exc_fire_i,
  input  mode_t exc_mode_i,
  input  logic  sw_fire_i,
  input  ctrl_t wr_mask_i,
  input  ctrl_t wr_data_i,
  input  logic  f_wr_ok_i,
  output ctrl_t ctrl_o
);
  ctrl_t ctrl_q, ctrl_d, merged;
  logic  cand_legal;

  assign merged = (ctrl_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);

  psr_mode_check u_cand_chk (
    .mode_i (merged[MODE_W-1:0]),
    .legal_o(cand_legal)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (exc_fire_i) begin
      ctrl_d[MODE_W-1:0] = exc_mode_i;
      ctrl_d[BIT_I]      = 1'b1;
      if (exc_mode_i == MODE_FIQ) ctrl_d[BIT_F] = 1'b1;
    end else if (sw_fire_i) begin
      ctrl_d[BIT_I] = merged[BIT_I];
      if (f_wr_ok_i) ctrl_d[BIT_F] = merged[BIT_F];
      if (cand_legal) ctrl_d[MODE_W-1:0] = merged[MODE_W-1:0];
      // state bit deliberately untouched by software
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  a_r5_t_sw_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_fire_i |=> $stable(ctrl_q[BIT_T]));

  a_r6_live_f_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_fire_i && !f_wr_ok_i && !exc_fire_i) |=> $stable(ctrl_q[BIT_F]));

  a_r8_exc_i_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_fire_i |=> (ctrl_q[BIT_I] && ctrl_q[MODE_W-1:0] == $past(exc_mode_i)));

  a_r7_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_fire_i && !exc_fire_i && !cand_legal) |=> $stable(ctrl_q[MODE_W-1:0]));
endmodule

// File: rtl/psr_saved_reg.sv
module psr_saved_reg
  import psr_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  exc_fire_i,
  input  ctrl_t live_i,
  input  logic  sw_fire_i,
  input  ctrl_t wr_mask_i,
  input  ctrl_t wr_data_i,
  output ctrl_t saved_o
);
  ctrl_t saved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        saved_q <= CTRL_RST;
    else if (exc_fire_i) saved_q <= live_i;
    else if (sw_fire_i)  saved_q <= (saved_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
  end

  assign saved_o = saved_q;

  a_r8_saved_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_fire_i |=> saved_q == $past(live_i));
endmodule

// File: rtl/psr_int_gate.sv
module psr_int_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic i_dis_i,
  input  logic f_dis_i,
  input  logic secure_i,
  input  logic fw_i,
  input  logic irq_req_i,
  input  logic fiq_req_i,
  output logic irq_o,
  output logic fiq_o
);
  logic fiq_maskable;

  assign fiq_maskable = secure_i | fw_i;
  assign irq_o        = irq_req_i & ~i_dis_i;
  assign fiq_o        = fiq_req_i & ~(f_dis_i & fiq_maskable);

  a_r3_fiq_unmaskable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_req_i && !secure_i && !fw_i) |-> fiq_o);

  a_r2_irq_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_dis_i |-> !irq_o);
endmodule

// File: rtl/psr_ctrl_unit.sv
module psr_ctrl_unit
  import psr_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_saved_i,
  input  logic [7:0] wr_mask_i,
  input  logic [7:0] wr_data_i,
  input  logic       secure_i,
  input  logic       fw_i,
  input  logic       exc_en_i,
  input  logic [4:0] exc_mode_i,
  input  logic       irq_req_i,
  input  logic       fiq_req_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] saved_o,
  output logic [4:0] mode_o,
  output logic       t_o,
  output logic       irq_o,
  output logic       fiq_o
);
  ctrl_t live, saved;
  logic  exc_legal, exc_fire, priv, sw_fire;

  psr_mode_check u_exc_chk (
    .mode_i (exc_mode_i),
    .legal_o(exc_legal)
  );

  assign exc_fire = exc_en_i & exc_legal;
  assign priv     = live[MODE_W-1:0] != MODE_USR;
  assign sw_fire  = wr_en_i & priv & ~exc_fire;

  psr_live_reg u_live (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exc_fire_i(exc_fire),
    .exc_mode_i(exc_mode_i),
    .sw_fire_i (sw_fire & ~wr_saved_i),
    .wr_mask_i (wr_mask_i),
    .wr_data_i (wr_data_i),
    .f_wr_ok_i (secure_i | fw_i),
    .ctrl_o    (live)
  );

  psr_saved_reg u_saved (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exc_fire_i(exc_fire),
    .live_i    (live),
    .sw_fire_i (sw_fire & wr_saved_i),
    .wr_mask_i (wr_mask_i),
    .wr_data_i (wr_data_i),
    .saved_o   (saved)
  );

  psr_int_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .i_dis_i  (live[BIT_I]),
    .f_dis_i  (live[BIT_F]),
    .secure_i (secure_i),
    .fw_i     (fw_i),
    .irq_req_i(irq_req_i),
    .fiq_req_i(fiq_req_i),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
  );

  assign ctrl_o  = live;
  assign saved_o = saved;
  assign mode_o  = live[MODE_W-1:0];
  assign t_o     = live[BIT_T];

  a_r4_user_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_USR && !exc_en_i) |=> (ctrl_o == $past(ctrl_o) && saved_o == $past(saved_o)));

  a_r9_bad_exc_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_en_i && !exc_legal && !wr_en_i) |=> ($stable(ctrl_o) && $stable(saved_o)));
endmodule

// File: tb/psr_ctrl_unit_tb.sv
`timescale 1ns/1ps
module psr_ctrl_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, wr_saved = 0, secure = 1, fw = 0, exc_en = 0;
  logic       irq_req = 0, fiq_req = 0;
  logic [7:0] wr_mask = 0, wr_data = 0;
  logic [4:0] exc_mode = 0;
  logic [7:0] ctrl, saved;
  logic [4:0] mode;
  logic       t, irq, fiq;

  int total = 0, bad = 0;
  bit done = 0;

  logic [15:0] q_val[$];
  string       q_req[$];
  logic [7:0]  m_live = 8'hD3, m_saved = 8'hD3;

  always #2 clk = ~clk;

  psr_ctrl_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_saved_i(wr_saved),
    .wr_mask_i(wr_mask), .wr_data_i(wr_data), .secure_i(secure), .fw_i(fw),
    .exc_en_i(exc_en), .exc_mode_i(exc_mode), .irq_req_i(irq_req),
    .fiq_req_i(fiq_req), .ctrl_o(ctrl), .saved_o(saved), .mode_o(mode),
    .t_o(t), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic bit legal(logic [4:0] m);
    return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h16, 5'h17, 5'h1B, 5'h1F};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push expected bytes after the edge
  task automatic step(string req, logic en, logic sav, logic [7:0] msk, logic [7:0] dat,
                      logic sec, logic f, logic ex, logic [4:0] exm);
    logic [7:0] nl, ns, mg;
    @(negedge clk);
    wr_en = en; wr_saved = sav; wr_mask = msk; wr_data = dat;
    secure = sec; fw = f; exc_en = ex; exc_mode = exm;
    nl = m_live; ns = m_saved;
    if (ex && legal(exm)) begin
      ns = m_live;
      nl[4:0] = exm;
      nl[7] = 1'b1;
      if (exm == 5'h11) nl[6] = 1'b1;
    end else if (en && m_live[4:0] != 5'h10) begin
      if (sav) ns = (m_saved & ~msk) | (dat & msk);
      else begin
        mg = (m_live & ~msk) | (dat & msk);
        nl[7] = mg[7];
        if (sec || f) nl[6] = mg[6];
        if (legal(mg[4:0])) nl[4:0] = mg[4:0];
      end
    end
    @(posedge clk);
    m_live = nl; m_saved = ns;
    q_val.push_back({nl, ns});
    q_req.push_back(req);
  endtask

  task automatic idle();
    step("idle", 0, 0, 8'h00, 8'h00, 1, 0, 0, 5'h00);
  endtask

  task automatic chk_gate(string req, logic ir, logic fr, logic sec, logic f,
                          logic exp_irq, logic exp_fiq);
    @(negedge clk);
    wr_en = 0; exc_en = 0;
    irq_req = ir; fiq_req = fr; secure = sec; fw = f;
    #1;
    check(req, {14'd0, irq, fiq}, {14'd0, exp_irq, exp_fiq});
  endtask

  // monitor: compare register results against the scoreboard
  always @(negedge clk) begin
    while (q_val.size() > 0) begin
      logic [15:0] e;
      string r;
      e = q_val.pop_front();
      r = q_req.pop_front();
      check(r, {ctrl, saved}, e);
      check(r, {8'd0, 2'd0, t, mode}, {8'd0, 2'd0, e[13], e[12:8]});
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", {ctrl, saved}, 16'hD3D3);
    // R2/R3 gating with I=F=1
    chk_gate("R2", 1, 0, 1, 0, 0, 0);
    chk_gate("R3 secure", 0, 1, 1, 0, 0, 0);
    chk_gate("R3 ns fw0", 0, 1, 0, 0, 0, 1);
    chk_gate("R3 ns fw1", 0, 1, 0, 1, 0, 0);
    // R5 full live write to system, interrupts enabled
    step("R5", 1, 0, 8'hFF, 8'h1F, 1, 0, 0, 5'h00);
    chk_gate("R2 enabled", 1, 1, 1, 0, 1, 1);
    step("R5 t", 1, 0, 8'h20, 8'h20, 1, 0, 0, 5'h00);
    // R6 live F dropped, saved F taken
    step("R6 live", 1, 0, 8'h40, 8'h40, 0, 0, 0, 5'h00);
    step("R6 saved", 1, 1, 8'h40, 8'h40, 0, 0, 0, 5'h00);
    step("R6 fw1", 1, 0, 8'h40, 8'h40, 0, 1, 0, 5'h00);
    chk_gate("R3 F set secure", 0, 1, 1, 0, 0, 0);
    // R7 illegal mode, I still updates
    step("R7", 1, 0, 8'h9F, 8'h95, 1, 0, 0, 5'h00);
    step("R7 clr", 1, 0, 8'hC0, 8'h00, 1, 0, 0, 5'h00);
    // R8 exception to IRQ with a colliding write
    step("R8 irq", 1, 0, 8'hFF, 8'h10, 1, 0, 1, 5'h12);
    step("R7 clr2", 1, 0, 8'h80, 8'h00, 1, 0, 0, 5'h00);
    step("R8 fiq", 0, 0, 8'h00, 8'h00, 1, 0, 1, 5'h11);
    // R9 illegal exception target
    step("R9", 0, 0, 8'h00, 8'h00, 1, 0, 1, 5'h05);
    step("R9 b", 0, 0, 8'h00, 8'h00, 1, 0, 1, 5'h1C);
    // R10 saved write, unchecked mode and state bit
    step("R10", 1, 1, 8'hFF, 8'h35, 1, 0, 0, 5'h00);
    // R4 drop to user, then writes ignored
    step("R4 enter", 1, 0, 8'h1F, 8'h10, 1, 0, 0, 5'h00);
    step("R4 live", 1, 0, 8'hFF, 8'h1F, 1, 1, 0, 5'h00);
    step("R4 saved", 1, 1, 8'hFF, 8'h00, 1, 1, 0, 5'h00);
    step("R8 from user", 0, 0, 8'h00, 8'h00, 1, 0, 1, 5'h13);
    idle();
    @(negedge clk);
    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule